// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block is the status byte of one up/down timer channel. It watches the counter as it steps and raises sticky flags for counter wrap in either direction and for two compare/capture channels, A and B. It also reports the current count direction. Software reads the byte over a simple strobe bus. To clear a flag, software writes a 0 to its bit, and the write only takes effect if an earlier read returned that flag as 1. Two transfer engines can also clear the compare/capture flags automatically when they service the matching interrupt, each one gated by its own qualifier.

Each status flag drives a level interrupt request that stays high while the flag is set. A per-flag arming latch records that software has seen the flag as 1. If a set event and a clear event arrive in the same cycle, the set wins, so no event is lost. The counter, the prescaler and the interrupt controller sit outside this block.

Top module: `tmr_stat_reg`

## Requirements
- R1: During and after a synchronous reset, `stat` reads 0xC0 (bit 7 = 1, bit 6 = 1, all other bits 0) and all four interrupt requests are 0.
- R2: Bit 7 of `stat` shows the value `cnt_up` had at the previous clock edge: 1 while counting up, 0 while counting down.
- R3: The overflow flag (bit 4) sets on a `cnt_step` with `cnt_up`=1 where the previous count was all ones and the new count is 0. The underflow flag (bit 5) sets on a `cnt_step` with `cnt_up`=0 where the previous count was 0 and the new count is all ones. The previous count is the count given with the last `cnt_step`, or 0 after reset.
- R4: When a channel is in compare mode (`mode_sel` bit = 0), its flag (A = bit 0 and `mode_sel[0]`, B = bit 1 and `mode_sel[1]`) sets on a `cnt_step` whose count equals that channel's register.
- R5: When a channel is in capture mode (`mode_sel` bit = 1), its flag sets on that channel's `cap_stb` bit (A = bit 0, B = bit 1), and a compare match has no effect.
- R6: A CPU write with a 0 in a flag's bit clears the flag only if a CPU read made since the flag last cleared returned that flag as 1. A 0-write with no such read leaves the flag at 1.
- R7: Writing 1 to any bit has no effect. Bit 6 always reads 1 and bits 3 and 2 always read 0, whatever is written.
- R8: Flag A clears on `dtc_ack_a` when `dtc_keep`=0, and on `dma_ack_a` when `dma_en`=1. It does not clear on `dtc_ack_a` with `dtc_keep`=1, nor on `dma_ack_a` with `dma_en`=0.
- R9: Flag B clears automatically only on `dtc_ack_b` when `dtc_keep`=0. `dma_ack_a` never clears flag B. The overflow and underflow flags have no automatic clear.
- R10: If a flag's set condition and any of its clear events occur in the same cycle, the flag is 1 afterwards.
- R11: `irq_a`, `irq_b`, `irq_ovf` and `irq_unf` are each equal to their flag bit (0, 1, 4 and 5) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Counter value, new value when `cnt_step` is high |
| cnt_up | input | 1 | Count direction, 1 = up |
| cnt_step | input | 1 | Counter took a step this cycle |
| mode_sel | input | 2 | Per channel: 0 = compare, 1 = capture (bit 0 = A) |
| cap_stb | input | 2 | Capture strobes (bit 0 = A) |
| gr_a | input | CNT_W | Channel A register contents |
| gr_b | input | CNT_W | Channel B register contents |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| dma_ack_a | input | 1 | DMA engine serviced the A interrupt |
| dma_en | input | 1 | DMA clear qualifier, 1 = clear |
| dtc_ack_a | input | 1 | Transfer controller serviced the A interrupt |
| dtc_ack_b | input | 1 | Transfer controller serviced the B interrupt |
| dtc_keep | input | 1 | Transfer controller keep qualifier, 0 = clear |
| stat | output | 8 | Status byte |
| irq_a | output | 1 | Flag A interrupt request |
| irq_b | output | 1 | Flag B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_unf | output | 1 | Underflow interrupt request |

## Verification
The bench builds the block with `CNT_W` = 4. With that width both wrap points, 15 to 0 and 0 to 15, come within a couple of steps, and the wrap detection is still exercised at full width because the comparison is against an all-ones value derived from `CNT_W`. Compare values in the same small range let matches, captures, arming reads and every auto-clear qualifier combination be lined up against each other in the same cycle, which is how the priority of set over clear is reached.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int NFLAG = 4;
  localparam int FL_A   = 0;
  localparam int FL_B   = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;

  function automatic int bitpos(input int idx);
    case (idx)
      FL_A:    return 0;
      FL_B:    return 1;
      FL_OVF:  return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/tsr_event_det.sv
module tsr_event_det #(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         cnt_val,
  input  logic                     cnt_up,
  input  logic                     cnt_step,
  input  logic [1:0]               mode_sel,
  input  logic [1:0]               cap_stb,
  input  logic [1:0][CNT_W-1:0]    gr_val,
  output logic [tsr_pkg::NFLAG-1:0] set_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst)           last_q <= CNT_ZERO;
    else if (cnt_step) last_q <= cnt_val;
  end

  genvar ch;
  generate
    for (ch = 0; ch < 2; ch++) begin : g_ch
      always_comb begin
        if (mode_sel[ch]) set_o[ch] = cap_stb[ch];
        else              set_o[ch] = cnt_step && (cnt_val == gr_val[ch]);
      end
    end
  endgenerate

  assign set_o[tsr_pkg::FL_OVF] = cnt_step && cnt_up &&
                                  (last_q == CNT_MAX) && (cnt_val == CNT_ZERO);
  assign set_o[tsr_pkg::FL_UNF] = cnt_step && !cnt_up &&
                                  (last_q == CNT_ZERO) && (cnt_val == CNT_MAX);
endmodule

// File: rtl/tsr_flag_cell.sv
module tsr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_zero_i,
  input  logic auto_clr_i,
  output logic flag_o,
  output logic arm_o
);
  logic clr;

  assign clr = (wr_zero_i && arm_o) || auto_clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      arm_o  <= 1'b0;
    end else begin
      flag_o <= set_i || (flag_o && !clr);
      arm_o  <= (rd_i && flag_o) || (arm_o && flag_o && !clr);
    end
  end
endmodule

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic             cnt_step,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       cap_stb,
  input  logic [CNT_W-1:0] gr_a,
  input  logic [CNT_W-1:0] gr_b,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  input  logic             dma_ack_a,
  input  logic             dma_en,
  input  logic             dtc_ack_a,
  input  logic             dtc_ack_b,
  input  logic             dtc_keep,
  output logic [7:0]       stat,
  output logic             irq_a,
  output logic             irq_b,
  output logic             irq_ovf,
  output logic             irq_unf
);
  import tsr_pkg::*;

  logic [NFLAG-1:0]       set_v;
  logic [NFLAG-1:0]       flag_v;
  logic [NFLAG-1:0]       arm_v;
  logic [NFLAG-1:0]       auto_v;
  logic [1:0][CNT_W-1:0]  gr_v;
  logic                   dir_q;
  logic                   unused_wd;

  assign gr_v      = {gr_b, gr_a};
  assign unused_wd = ^{bus_wdata[7:6], bus_wdata[3:2]};

  tsr_event_det #(.CNT_W(CNT_W)) u_det (
    .clk      (clk),
    .rst      (rst),
    .cnt_val  (cnt_val),
    .cnt_up   (cnt_up),
    .cnt_step (cnt_step),
    .mode_sel (mode_sel),
    .cap_stb  (cap_stb),
    .gr_val   (gr_v),
    .set_o    (set_v)
  );

  assign auto_v[FL_A]   = (dtc_ack_a && !dtc_keep) || (dma_ack_a && dma_en);
  assign auto_v[FL_B]   = dtc_ack_b && !dtc_keep;
  assign auto_v[FL_OVF] = 1'b0;
  assign auto_v[FL_UNF] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < NFLAG; i++) begin : g_flag
      tsr_flag_cell u_cell (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_v[i]),
        .rd_i       (bus_rd),
        .wr_zero_i  (bus_wr && !bus_wdata[bitpos(i)]),
        .auto_clr_i (auto_v[i]),
        .flag_o     (flag_v[i]),
        .arm_o      (arm_v[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dir_q <= 1'b1;
    else     dir_q <= cnt_up;
  end

  always_comb begin
    stat    = 8'h40;
    stat[7] = dir_q;
    for (int k = 0; k < NFLAG; k++) stat[bitpos(k)] = flag_v[k];
  end

  assign irq_a   = flag_v[FL_A];
  assign irq_b   = flag_v[FL_B];
  assign irq_ovf = flag_v[FL_OVF];
  assign irq_unf = flag_v[FL_UNF];
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker (
  input logic       clk,
  input logic       rst,
  input logic       cnt_up,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       dma_ack_a,
  input logic       dma_en,
  input logic       dtc_ack_a,
  input logic       dtc_ack_b,
  input logic       dtc_keep,
  input logic [7:0] stat,
  input logic       irq_a,
  input logic       irq_b,
  input logic       irq_ovf,
  input logic       irq_unf,
  input logic [3:0] set_v,
  input logic [3:0] arm_v
);
  logic auto_a;
  assign auto_a = (dtc_ack_a && !dtc_keep) || (dma_ack_a && dma_en);

  AST_DIR_UP: assert property (@(posedge clk) disable iff (rst) cnt_up |=> stat[7]); // R2
  AST_DIR_DN: assert property (@(posedge clk) disable iff (rst) !cnt_up |=> !stat[7]); // R2
  AST_SET_WINS_A: assert property (@(posedge clk) disable iff (rst) set_v[0] |=> stat[0]); // R10
  AST_SET_WINS_B: assert property (@(posedge clk) disable iff (rst) set_v[1] |=> stat[1]); // R10
  AST_NOARM_KEEP: assert property (@(posedge clk) disable iff (rst)
    (stat[0] && !arm_v[0] && bus_wr && !bus_wdata[0] && !auto_a) |=> stat[0]); // R6
  AST_WR1_NOSET: assert property (@(posedge clk) disable iff (rst)
    (!stat[4] && bus_wr && bus_wdata[4] && !set_v[2]) |=> !stat[4]); // R7
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stat[4] && !bus_wr) |=> stat[4]); // R9
  AST_DMA_NOT_B: assert property (@(posedge clk) disable iff (rst)
    (stat[1] && dma_ack_a && dma_en && !bus_wr && !(dtc_ack_b && !dtc_keep)) |=> stat[1]); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq_a == stat[0]) && (irq_b == stat[1]) && (irq_ovf == stat[4]) && (irq_unf == stat[5])); // R11
endmodule

bind tmr_stat_reg tsr_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_up    (cnt_up),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .dma_ack_a (dma_ack_a),
  .dma_en    (dma_en),
  .dtc_ack_a (dtc_ack_a),
  .dtc_ack_b (dtc_ack_b),
  .dtc_keep  (dtc_keep),
  .stat      (stat),
  .irq_a     (irq_a),
  .irq_b     (irq_b),
  .irq_ovf   (irq_ovf),
  .irq_unf   (irq_unf),
  .set_v     (set_v),
  .arm_v     (arm_v)
);

// File: tb/sim_tmr_stat_reg.sv
`timescale 1ns/1ps
module sim_tmr_stat_reg;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst = 1;
  logic [W-1:0] cnt_val = 0, gr_a = 0, gr_b = 0;
  logic cnt_up = 1, cnt_step = 0;
  logic [1:0] mode_sel = 0, cap_stb = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic dma_ack_a = 0, dma_en = 0, dtc_ack_a = 0, dtc_ack_b = 0, dtc_keep = 0;
  logic [7:0] stat;
  logic irq_a, irq_b, irq_ovf, irq_unf;

  int total = 0, bad = 0;
  string tag = "R1";

  int m_f[4];
  int m_arm[4];
  int m_dir, m_last;
  int pos[4] = '{0, 1, 4, 5};

  always #4 clk = ~clk;

  tmr_stat_reg #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_up(cnt_up), .cnt_step(cnt_step),
    .mode_sel(mode_sel), .cap_stb(cap_stb), .gr_a(gr_a), .gr_b(gr_b),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .dma_ack_a(dma_ack_a), .dma_en(dma_en), .dtc_ack_a(dtc_ack_a),
    .dtc_ack_b(dtc_ack_b), .dtc_keep(dtc_keep),
    .stat(stat), .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf), .irq_unf(irq_unf)
  );

  task automatic mdl();
    int s[4];
    int au[4];
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_f[i] = 0; m_arm[i] = 0; end
      m_dir = 1; m_last = 0;
      return;
    end
    s[0] = mode_sel[0] ? int'(cap_stb[0]) : int'(cnt_step && int'(cnt_val) == int'(gr_a));
    s[1] = mode_sel[1] ? int'(cap_stb[1]) : int'(cnt_step && int'(cnt_val) == int'(gr_b));
    s[2] = int'(cnt_step && cnt_up && m_last == MAXV && cnt_val == 0);
    s[3] = int'(cnt_step && !cnt_up && m_last == 0 && int'(cnt_val) == MAXV);
    au[0] = int'((dtc_ack_a && !dtc_keep) || (dma_ack_a && dma_en));
    au[1] = int'(dtc_ack_b && !dtc_keep);
    au[2] = 0; au[3] = 0;
    for (int i = 0; i < 4; i++) begin
      int clr, nf, na;
      clr = int'((bus_wr && !bus_wdata[pos[i]] && m_arm[i] != 0) || au[i] != 0);
      nf = (s[i] != 0 || (m_f[i] != 0 && clr == 0)) ? 1 : 0;
      na = ((bus_rd && m_f[i] != 0) || (m_arm[i] != 0 && m_f[i] != 0 && clr == 0)) ? 1 : 0;
      m_f[i] = nf; m_arm[i] = na;
    end
    m_dir = int'(cnt_up);
    if (cnt_step) m_last = int'(cnt_val);
  endtask

  task automatic chk();
    logic [7:0] e;
    logic [3:0] ei, ai;
    e = 8'h40;
    e[7] = m_dir[0];
    for (int i = 0; i < 4; i++) e[pos[i]] = m_f[i][0];
    ei = {e[5], e[4], e[1], e[0]};
    ai = {irq_unf, irq_ovf, irq_b, irq_a};
    total++;
    if (stat !== e) begin
      bad++;
      $display("FAIL %s stat actual=%h expected=%h", tag, stat, e);
    end
    total++;
    if (ai !== ei) begin
      bad++;
      $display("FAIL %s/R11 irq actual=%b expected=%b", tag, ai, ei);
    end
  endtask

  task automatic step();
    @(posedge clk);
    mdl();
    @(negedge clk);
    chk();
    cnt_step = 0; cap_stb = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    dma_ack_a = 0; dtc_ack_a = 0; dtc_ack_b = 0;
  endtask

  task automatic cstep(input int v, input logic up);
    cnt_val = v[W-1:0]; cnt_up = up; cnt_step = 1; step();
  endtask

  task automatic rd();
    bus_rd = 1; step();
  endtask

  task automatic wr(input logic [7:0] d);
    bus_wr = 1; bus_wdata = d; step();
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; step(); step();
    rst = 0; step();
    tag = "R2"; cnt_up = 0; step(); step(); cnt_up = 1; step();
    tag = "R3"; cstep(14, 1); cstep(15, 1); cstep(0, 1);
    cstep(15, 0);
    cstep(0, 0); cstep(15, 0);
    tag = "R6"; wr(8'h00); step();
    rd(); wr(8'hEF); step();
    rd(); wr(8'h00); step();
    tag = "R7"; wr(8'hFF); step(); wr(8'h00); step();
    tag = "R4"; gr_a = 5; gr_b = 7; cstep(4, 1); cstep(5, 1); cstep(6, 1); cstep(7, 1);
    tag = "R5"; mode_sel = 2'b11; gr_a = 2; cstep(2, 1);
    rd(); wr(8'h00);
    cstep(2, 1); cap_stb = 2'b01; step(); cap_stb = 2'b10; step();
    tag = "R8"; dtc_keep = 1; dtc_ack_a = 1; step();
    dtc_keep = 0; dtc_ack_a = 1; step();
    cap_stb = 2'b01; step();
    dma_en = 0; dma_ack_a = 1; step();
    dma_en = 1; dma_ack_a = 1; step();
    tag = "R9"; cap_stb = 2'b11; step();
    dma_ack_a = 1; step();
    dtc_keep = 1; dtc_ack_b = 1; step();
    dtc_keep = 0; dtc_ack_b = 1; step();
    cstep(15, 1); cstep(0, 1); dtc_ack_a = 1; dtc_ack_b = 1; dma_ack_a = 1; step();
    tag = "R10"; cap_stb = 2'b11; dtc_ack_a = 1; dtc_ack_b = 1; step();
    rd(); cap_stb = 2'b01; bus_wr = 1; bus_wdata = 8'h00; step();
    cstep(15, 0); cstep(0, 0);
    rd(); cstep(15, 0); bus_wr = 1; bus_wdata = 8'h00; step();
    tag = "R6"; rd(); wr(8'h00); step();
    tag = "R1"; rst = 1; step(); rst = 0; step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule